// File: doc/BRIEF.md
# Zero-Terminated Frame Survivor Store and Traceback

This block sits behind the add-compare-select stage of a four-state, rate one-half trellis decoder. Every cycle that the metric stage presents a decision vector, the block writes it into a single-port survivor memory. The vector holds one bit per trellis state, and the memory keeps one entry per trellis step of the frame. When the final step of the frame has been stored, the block raises its decode-enable flag and walks the stored trellis backwards. Because the sender appends zero tail bits, the walk always begins in state 0 at the newest step.

Each traceback step yields one message bit. The bits leave the block newest first, so the consumer reverses their order. After the oldest step has been consumed, a one-cycle done pulse closes the frame and the block is ready for the next one. While a traceback is in progress the memory port belongs to the read side, so decision vectors offered during that time are dropped.

Top module: `frame_traceback`

## Requirements
- R1: While reset is held and in the first cycle after it, decodeEn, bitValid and decodeDone are all low.
- R2: Outside traceback, each cycle with decValid high stores decVec at the next step position. Positions start at 0 for every frame and rise by one per accepted vector, up to DEPTH-1.
- R3: decodeEn goes high in the cycle after the vector for step DEPTH-1 is accepted, and never earlier. It stays high through the traceback and the done cycle, then drops.
- R4: Traceback starts at step DEPTH-1 in state 0.
- R5: The state is written s = {s1,s0}, with s1 the newest input bit. At a step in state s, the emitted bit is s1. The next state is {s0, d}, where d is bit s of the decision vector stored for that step, and bit index i of decVec belongs to state i.
- R6: bitValid is a single-cycle pulse issued once per two cycles of traceback. The first pulse comes two cycles after decodeEn rises.
- R7: Exactly DEPTH bits are emitted per frame, in order from step DEPTH-1 down to step 0.
- R8: decodeDone is a one-cycle pulse in the same cycle as the final bitValid. In the cycle after it, a new frame may begin.
- R9: decValid during traceback or during the done cycle is ignored. It changes neither the stored decisions being traced nor the step position of the next frame.
- R10: Idle cycles (decValid low) may occur anywhere inside a fill without affecting the decoded result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| decValid | input | 1 | Decision vector strobe |
| decVec | input | 1<<STATE_W | Decision bits, bit i for trellis state i |
| decodeEn | output | 1 | High from the end of the fill through the done cycle |
| bitValid | output | 1 | Strobe for bitOut |
| bitOut | output | 1 | Decoded bit, newest step first |
| decodeDone | output | 1 | One-cycle end-of-frame pulse |

## Verification
Two pairs of events can land in the same cycle. First, decodeDone coincides with the last decoded bit, and the bench checks that both are high together and that neither repeats. Second, a decision strobe can arrive while the read side owns the memory. The bench drives junk vectors on decValid in every traceback and done cycle. It then judges the result through the decoded bits of the current frame and through a correct decode of the following frame, which would be misaligned if a refused write had moved the fill position.

// File: rtl/trace_pkg.sv
package trace_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_TRACE = 2'd2,
    ST_DONE  = 2'd3
  } tbPhase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;    // store decVec at the fill position
    logic rdEn;    // read the survivor entry at the trace position
    logic loadTb;  // last write of the frame: arm traceback
    logic stepTb;  // consume the registered entry, emit one bit
  } tbCtl_t;

endpackage

// File: rtl/survivor_ram.sv
module survivor_ram #(
  parameter int DEPTH = 4096,
  parameter int WIDTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] store [DEPTH];

  // single port: one access per cycle, read data registered
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) store[addr] <= wdata;
      else    rdata       <= store[addr];
    end
  end

endmodule

// File: rtl/trace_datapath.sv
module trace_datapath
  import trace_pkg::*;
#(
  parameter int DEPTH   = 4096,
  parameter int STATE_W = 2,
  localparam int DEC_W  = 1 << STATE_W,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam logic [AW-1:0] LAST_STEP = AW'(DEPTH - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tbCtl_t           ctl,
  input  logic [DEC_W-1:0] decVec,
  output logic             wrLast,
  output logic             rdFirst,
  output logic             bitValid,
  output logic             bitOut
);

  logic [AW-1:0]      wrAddr;
  logic [AW-1:0]      rdAddr;
  logic [STATE_W-1:0] tbState;
  logic [DEC_W-1:0]   rdData;
  logic [AW-1:0]      ramAddr;
  logic               ramEn;
  logic               pickedBit;

  assign ramEn   = ctl.wrEn | ctl.rdEn;
  assign ramAddr = ctl.rdEn ? rdAddr : wrAddr;
  assign wrLast  = (wrAddr == LAST_STEP);
  assign rdFirst = (rdAddr == '0);
  assign pickedBit = rdData[tbState];

  survivor_ram #(
    .DEPTH (DEPTH),
    .WIDTH (DEC_W)
  ) i_ram (
    .clk   (clk),
    .en    (ramEn),
    .we    (ctl.wrEn),
    .addr  (ramAddr),
    .wdata (decVec),
    .rdata (rdData)
  );

  // fill position
  always_ff @(posedge clk) begin
    if (!rst_n)           wrAddr <= '0;
    else if (ctl.loadTb)  wrAddr <= '0;
    else if (ctl.wrEn)    wrAddr <= wrAddr + AW'(1);
  end

  // trace position and trellis state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdAddr  <= '0;
      tbState <= '0;
    end else if (ctl.loadTb) begin
      rdAddr  <= LAST_STEP;
      tbState <= '0;
    end else if (ctl.stepTb) begin
      rdAddr  <= rdAddr - AW'(1);
      tbState <= {tbState[STATE_W-2:0], pickedBit};
    end
  end

  // decoded bit output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bitValid <= 1'b0;
      bitOut   <= 1'b0;
    end else begin
      bitValid <= ctl.stepTb;
      if (ctl.stepTb) bitOut <= tbState[STATE_W-1];
    end
  end

  // R9: the single port never sees a write and a read together
  p_single_port_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.wrEn && ctl.rdEn));

  // R6: decoded bits are isolated single-cycle pulses
  p_bit_spacing_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    bitValid |=> !bitValid);

  // R7: each step moves one entry towards the oldest step
  p_step_order_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.stepTb && !rdFirst) |=> (rdAddr == $past(rdAddr) - AW'(1)));

  // R4: arming the traceback selects state 0 at the newest step
  p_start_zero_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    ctl.loadTb |=> (tbState == '0) && (rdAddr == LAST_STEP) && (wrAddr == '0));

endmodule

// File: rtl/trace_control.sv
module trace_control
  import trace_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   decValid,
  input  logic   wrLast,
  input  logic   rdFirst,
  output tbCtl_t ctl,
  output logic   decodeEn,
  output logic   decodeDone
);

  tbPhase_e phase;
  logic     readHalf;  // 0: issue read, 1: consume registered entry
  logic     accepting;

  assign accepting = (phase == ST_IDLE) || (phase == ST_FILL);

  always_comb begin
    ctl        = '0;
    ctl.wrEn   = decValid && accepting;
    ctl.loadTb = decValid && accepting && wrLast;
    ctl.rdEn   = (phase == ST_TRACE) && !readHalf;
    ctl.stepTb = (phase == ST_TRACE) && readHalf;
  end

  assign decodeEn   = (phase == ST_TRACE) || (phase == ST_DONE);
  assign decodeDone = (phase == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= ST_IDLE;
      readHalf <= 1'b0;
    end else begin
      unique case (phase)
        ST_IDLE: begin
          readHalf <= 1'b0;
          if (ctl.loadTb)     phase <= ST_TRACE;
          else if (ctl.wrEn)  phase <= ST_FILL;
        end
        ST_FILL: begin
          readHalf <= 1'b0;
          if (ctl.loadTb) phase <= ST_TRACE;
        end
        ST_TRACE: begin
          readHalf <= !readHalf;
          if (ctl.stepTb && rdFirst) phase <= ST_DONE;
        end
        ST_DONE: begin
          readHalf <= 1'b0;
          phase    <= ST_IDLE;
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  // R3: decode enable only rises right after the final step is written
  p_en_after_fill_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(decodeEn) |-> $past(decValid && wrLast));

  // R8: done is a single pulse that also closes decode enable
  p_done_pulse_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    decodeDone |=> (!decodeDone && !decodeEn));

endmodule

// File: rtl/frame_traceback.sv
module frame_traceback
  import trace_pkg::*;
#(
  parameter int DEPTH   = 4096,
  parameter int STATE_W = 2,
  localparam int DEC_W  = 1 << STATE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             decValid,
  input  logic [DEC_W-1:0] decVec,
  output logic             decodeEn,
  output logic             bitValid,
  output logic             bitOut,
  output logic             decodeDone
);

  tbCtl_t ctl;
  logic   wrLast;
  logic   rdFirst;

  trace_control i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .decValid   (decValid),
    .wrLast     (wrLast),
    .rdFirst    (rdFirst),
    .ctl        (ctl),
    .decodeEn   (decodeEn),
    .decodeDone (decodeDone)
  );

  trace_datapath #(
    .DEPTH   (DEPTH),
    .STATE_W (STATE_W)
  ) i_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .decVec   (decVec),
    .wrLast   (wrLast),
    .rdFirst  (rdFirst),
    .bitValid (bitValid),
    .bitOut   (bitOut)
  );

  // R8: the done pulse carries the oldest decoded bit
  p_done_last_bit_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    decodeDone |-> bitValid);

  // R6: no decoded bit without decode enable
  p_bit_needs_en_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    bitValid |-> decodeEn);

endmodule

// File: tb/test_frame_traceback.sv
module test_frame_traceback;

  localparam int CLK_PERIOD  = 10;
  localparam int BENCH_DEPTH = 32;
  localparam int LIMIT       = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       decValid = 1'b0;
  logic [3:0] decVec = 4'h0;
  logic       decodeEn, bitValid, bitOut, decodeDone;

  frame_traceback #(.DEPTH(BENCH_DEPTH), .STATE_W(2)) i_frame_traceback (
    .clk(clk), .rst_n(rst_n), .decValid(decValid), .decVec(decVec),
    .decodeEn(decodeEn), .bitValid(bitValid), .bitOut(bitOut),
    .decodeDone(decodeDone)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad   = 0;

  // behavioural reference: 0 accepting, 1 tracing, 2 done cycle
  int         mMode = 0, mWr = 0, mRd = 0, mPhase = 0, mState = 0;
  logic [3:0] mData = 4'h0;
  bit         mBitValid = 0, mBit = 0;
  logic [3:0] mMem [BENCH_DEPTH];
  bit         expBits [$];
  int         gotBits = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkCycle();
    check(decodeEn == (mMode != 0), "R3", "decodeEn", decodeEn, mMode != 0);
    check(decodeDone == (mMode == 2), "R8", "decodeDone", decodeDone, mMode == 2);
    check(bitValid == mBitValid, "R6", "bitValid", bitValid, mBitValid);
    if (mBitValid && bitValid) begin
      check(bitOut == mBit, "R5", "bitOut vs trellis walk", bitOut, mBit);
      gotBits++;
      if (expBits.size() == 0) check(0, "R7", "extra decoded bit", gotBits, BENCH_DEPTH);
      else begin
        bit e = expBits.pop_front();
        check(bitOut == e, "R2 R4 R7", "bitOut vs message", bitOut, e);
      end
    end
  endtask

  task automatic advance();
    case (mMode)
      0: begin
        mBitValid = 0;
        if (decValid) begin
          mMem[mWr] = decVec;
          if (mWr == BENCH_DEPTH-1) begin
            mMode = 1; mRd = BENCH_DEPTH-1; mPhase = 0; mState = 0; mWr = 0;
          end else mWr++;
        end
      end
      1: begin
        if (mPhase == 0) begin
          mData = mMem[mRd]; mPhase = 1; mBitValid = 0;
        end else begin
          mBit = mState[1];
          mBitValid = 1;
          mState = ((mState & 1) << 1) | int'(mData[mState]);
          if (mRd == 0) mMode = 2; else mRd--;
          mPhase = 0;
        end
      end
      default: begin
        mMode = 0; mBitValid = 0;
      end
    endcase
  endtask

  task automatic runFrame(int kind, bit gaps, bit junk, string name);
    bit msg [BENCH_DEPTH];
    logic [3:0] vecs [BENCH_DEPTH];
    int idx = 0;
    bit seenDone = 0;
    for (int t = 0; t < BENCH_DEPTH; t++) begin
      case (kind)
        0: msg[t] = 1'($urandom);
        1: msg[t] = 1'b1;
        default: msg[t] = (t % 2 == 1);
      endcase
    end
    msg[BENCH_DEPTH-1] = 0;
    msg[BENCH_DEPTH-2] = 0;
    for (int t = 0; t < BENCH_DEPTH; t++) begin
      logic [3:0] v = 4'($urandom);
      int dest = {30'd0, msg[t], (t >= 1) ? msg[t-1] : 1'b0};
      v[dest] = (t >= 2) ? msg[t-2] : 1'b0;
      vecs[t] = v;
    end
    expBits.delete();
    for (int t = BENCH_DEPTH-1; t >= 0; t--) expBits.push_back(msg[t]);
    gotBits = 0;
    while (!(seenDone && mMode == 0)) begin
      @(negedge clk);
      checkCycle();
      if (mMode == 2) seenDone = 1;
      if (mMode == 0 && !seenDone && idx < BENCH_DEPTH &&
          (!gaps || $urandom_range(0, 2) != 0)) begin
        decValid = 1'b1; decVec = vecs[idx]; idx++;      // R10 gaps when enabled
      end else if (junk && mMode != 0) begin
        decValid = 1'b1; decVec = 4'($urandom);          // R9 refused writes
      end else begin
        decValid = 1'b0; decVec = 4'h0;
      end
      advance();
    end
    check(gotBits == BENCH_DEPTH, "R7", {name, " bit count"}, gotBits, BENCH_DEPTH);
    check(expBits.size() == 0, "R10", {name, " leftover bits"}, expBits.size(), 0);
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    check(0, "R7", "watchdog expired", LIMIT, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(!decodeEn && !bitValid && !decodeDone, "R1", "outputs in reset",
            {29'd0, decodeEn, bitValid, decodeDone}, 0);
    end
    rst_n = 1'b1;
    runFrame(0, 0, 1, "random frame");
    runFrame(1, 1, 1, "ones frame with gaps");
    runFrame(2, 0, 0, "alternating frame");
    runFrame(0, 1, 1, "random frame with gaps");
    runFrame(0, 0, 1, "back-to-back frame");
    @(negedge clk);
    checkCycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule